// File: doc/BRIEF.md
# TDM Serial Receiver with Frame Synchronisation

This block is the receive half of a time-division-multiplexed serial audio port. A serial data line is sampled once per bit period and cut into frames of up to 32 slots. The first bits of each slot make up a data word. Each completed word is offered as a parallel value, together with the index of the slot it came from and a level valid flag that stays high until the consumer acknowledges it.

The frame boundary comes from a frame sync. As a master, the block drives the sync itself from its own frame position counter. As a slave, it locks onto the rising edge of an external sync. The sync can be one word wide or one bit wide. A word-wide sync can be moved one bit period earlier. Slot length and word length are chosen independently.

A receiver-only soft reset clears the status flags and the framing state at once. The configuration inputs keep whatever values they hold. Everything runs in one system clock domain. `bit_tick` is a one-cycle enable that marks the bit-clock falling edge, which is the sample point for both data and sync.

Top module: `tdm_rx_sync`

## Requirements
- R1: Data is shifted in MSB first. A finished word of W bits appears in `word_data[W-1:0]` with all upper bits zero. `word_slot` carries its slot index, with slot 0 being the first slot after the frame sync.
- R2: Only the first `word_len` bits of a slot form the word. The other bits of the slot have no effect on any output.
- R3: `slot_len_sel` encodes the slot length: 0 = 12, 1 = 16, 2 = 20, 3 = 24 and 4 = 32 bits. Codes 5 to 7 are reserved. A reserved code, a `word_len` of 0, or a `word_len` larger than the slot length puts the receiver in idle: no word is captured and `sync_out` stays 0.
- R4: In slave mode with word-wide sync (`sync_bit_mode`=0, `sync_early`=0), a sample where `sync_in` is 1 and the previous sample was 0 is bit 0 of slot 0.
- R5: In slave mode with word-wide sync and `sync_early`=1, that rising edge marks the last bit of the previous frame, and the next sample is bit 0 of slot 0.
- R6: With `sync_bit_mode`=1 the sync is one bit period long and falls on bit 0 of slot 0. `sync_early` is ignored in this mode.
- R7: In master mode (`master_en`=1), `sync_out` gives the sync level for the bit that the next `bit_tick` samples. With word-wide sync it is high for bits 0 to W-1 of slot 0. With early sync it is high for the last bit of the final slot and bits 0 to W-2 of slot 0. With one-bit sync it is high for bit 0 of slot 0 only. The first frame starts at the first sample after reset or soft-reset release.
- R8: A frame holds `slots_m1`+1 slots (1 to 32). The slot index wraps to 0 after the last slot, and also wraps at every recognised sync.
- R9: `word_valid` rises one clock after the sample that completes a word. It stays high until `word_ack` is seen, and then falls one clock later.
- R10: If a word completes while `word_valid` is high and `word_ack` is low, `overrun` goes to 1 and the new word replaces the old one. `overrun` stays 1 until a reset or a soft reset.
- R11: While `rx_soft_rst` is 1, `word_valid`, `overrun` and `sync_out` read 0 in that same cycle and no word is captured. After release, the receiver works again with the configuration unchanged. A slave waits for the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| bit_tick | input | 1 | Sample enable, one pulse per bit period |
| sync_in | input | 1 | External frame sync (slave mode) |
| sdata_in | input | 1 | Serial data input |
| master_en | input | 1 | 1: generate the sync, 0: follow `sync_in` |
| sync_bit_mode | input | 1 | 1: one-bit sync, 0: word-wide sync |
| sync_early | input | 1 | Word-wide sync starts one bit early |
| slot_len_sel | input | 3 | Slot length code (see R3) |
| word_len | input | 6 | Word length in bits |
| slots_m1 | input | 5 | Slots per frame minus one |
| rx_soft_rst | input | 1 | Receiver-only soft reset |
| word_ack | input | 1 | Consumer acknowledge of the held word |
| sync_out | output | 1 | Generated frame sync (master mode) |
| word_data | output | 32 | Received word, right-justified |
| word_valid | output | 1 | A word is held and not yet acknowledged |
| word_slot | output | 5 | Slot index of the held word |
| overrun | output | 1 | Sticky flag: a word was overwritten |

## Verification
The bench targets how each sync form places the frame. An early sync taken as on-time would shift every word by one bit and corrupt its data. A one-bit sync that still honours the early flag would land a bit late. A word shorter than its slot tests whether the padding bits leak into the word or knock the slot index out of step. Frames of one slot and of thirty-two slots test the wrap. The overrun case checks that the second word wins and that the flag stays set after acknowledge. The soft-reset case checks that the flags drop in the same cycle, that a sync-bearing frame sent while reset is held produces no word, and that reception restarts with the held configuration. Reserved slot codes and words longer than their slot must give silence on both the word outputs and the generated sync.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    localparam int LEN_W = 6;

    typedef enum logic [2:0] {
        SLOT_12 = 3'd0,
        SLOT_16 = 3'd1,
        SLOT_20 = 3'd2,
        SLOT_24 = 3'd3,
        SLOT_32 = 3'd4
    } slot_code_e;

    // Slot length in bits for a code; 0 marks a reserved code.
    function automatic logic [LEN_W-1:0] slot_bits(input logic [2:0] code);
        case (code)
            SLOT_12: slot_bits = 6'd12;
            SLOT_16: slot_bits = 6'd16;
            SLOT_20: slot_bits = 6'd20;
            SLOT_24: slot_bits = 6'd24;
            SLOT_32: slot_bits = 6'd32;
            default: slot_bits = 6'd0;
        endcase
    endfunction
endpackage

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              sync_in,
    input  logic              master_en,
    input  logic              sync_bit_mode,
    input  logic              sync_early,
    input  logic [2:0]        slot_len_sel,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [SLOT_W-1:0] slots_m1,
    input  logic              rx_soft_rst,
    output logic              sync_out,
    output logic              cap_en,
    output logic              cap_first,
    output logic              cap_last,
    output logic [SLOT_W-1:0] cap_slot
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [LEN_W-1:0]  bitp;
        logic              locked;
        logic              pend;
        logic              prev;
    } fr_t;

    fr_t r_q, r_d;

    logic [LEN_W-1:0]  sl;
    logic              cfg_ok;
    logic              edge_seen;
    logic              start_now;
    logic              start_next;
    logic              cur_valid;
    logic [SLOT_W-1:0] cur_slot;
    logic [LEN_W-1:0]  cur_bit;
    logic              pat;

    always_comb begin
        sl         = slot_bits(slot_len_sel);
        cfg_ok     = (sl != '0) && (word_len != '0) && (word_len <= sl);
        edge_seen  = !master_en && sync_in && !r_q.prev;
        start_now  = edge_seen && (sync_bit_mode || !sync_early);
        start_next = edge_seen && !sync_bit_mode && sync_early;
        cur_valid  = master_en || r_q.locked || start_now || r_q.pend;
        if (!master_en && (start_now || r_q.pend)) begin
            cur_slot = '0;
            cur_bit  = '0;
        end else begin
            cur_slot = r_q.slot;
            cur_bit  = r_q.bitp;
        end

        r_d       = r_q;
        cap_en    = 1'b0;
        cap_first = (cur_bit == '0);
        cap_last  = (cur_bit == word_len - 1'b1);
        cap_slot  = cur_slot;

        if (rx_soft_rst || !cfg_ok) begin
            r_d = '0;
        end else if (bit_tick) begin
            r_d.prev = sync_in;
            r_d.pend = start_next;
            if (cur_valid) begin
                r_d.locked = 1'b1;
                cap_en     = (cur_bit < word_len);
                if (cur_bit >= sl - 1'b1) begin
                    r_d.bitp = '0;
                    r_d.slot = (cur_slot >= slots_m1) ? '0 : cur_slot + 1'b1;
                end else begin
                    r_d.bitp = cur_bit + 1'b1;
                    r_d.slot = cur_slot;
                end
            end
        end

        // Sync level for the bit the next tick samples.
        if (sync_bit_mode)
            pat = (r_q.slot == '0) && (r_q.bitp == '0);
        else if (sync_early)
            pat = ((r_q.slot == '0) && (r_q.bitp < word_len - 1'b1)) ||
                  ((r_q.slot == slots_m1) && (r_q.bitp == sl - 1'b1));
        else
            pat = (r_q.slot == '0) && (r_q.bitp < word_len);
        sync_out = master_en && cfg_ok && !rx_soft_rst && pat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R6: a generated one-bit sync lasts a single bit period
    p_bit_sync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && sync_bit_mode && sync_out && bit_tick) |=> !sync_out);
endmodule

// File: rtl/tdm_rx_shifter.sv
module tdm_rx_shifter #(
    parameter int DATA_W = 32,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_in,
    input  logic              rx_soft_rst,
    input  logic              word_ack,
    input  logic              cap_en,
    input  logic              cap_first,
    input  logic              cap_last,
    input  logic [SLOT_W-1:0] cap_slot,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic [SLOT_W-1:0] word_slot,
    output logic              overrun
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] data;
        logic [SLOT_W-1:0] slot;
        logic              valid;
        logic              ovr;
    } sh_t;

    sh_t s_q, s_d;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        s_d     = s_q;
        shifted = cap_first ? {{(DATA_W-1){1'b0}}, sdata_in}
                            : {s_q.sh[DATA_W-2:0], sdata_in};
        if (word_ack) s_d.valid = 1'b0;
        if (cap_en) begin
            s_d.sh = shifted;
            if (cap_last) begin
                s_d.data  = shifted;
                s_d.slot  = cap_slot;
                s_d.valid = 1'b1;
                if (s_q.valid && !word_ack) s_d.ovr = 1'b1;
            end
        end
        if (rx_soft_rst) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_data  = s_q.data;
    assign word_slot  = s_q.slot;
    assign word_valid = s_q.valid && !rx_soft_rst;
    assign overrun    = s_q.ovr && !rx_soft_rst;

    // R11: no capture while the soft reset is held
    p_no_capture_soft_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soft_rst |-> !cap_en);
    // R11: status state is empty after a soft-reset cycle
    p_soft_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soft_rst |=> (!s_q.valid && !s_q.ovr));
    // R10: overrun is sticky until a reset
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovr && !rx_soft_rst) |=> s_q.ovr);
    // R9: valid only rises after a completing sample
    p_valid_from_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.valid) |-> $past(cap_en && cap_last));
endmodule

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync
    import tdm_rx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MAX_SLOTS = 32,
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              sync_in,
    input  logic              sdata_in,
    input  logic              master_en,
    input  logic              sync_bit_mode,
    input  logic              sync_early,
    input  logic [2:0]        slot_len_sel,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [SLOT_W-1:0] slots_m1,
    input  logic              rx_soft_rst,
    input  logic              word_ack,
    output logic              sync_out,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic [SLOT_W-1:0] word_slot,
    output logic              overrun
);
    logic              cap_en;
    logic              cap_first;
    logic              cap_last;
    logic [SLOT_W-1:0] cap_slot;

    tdm_rx_framer #(.SLOT_W(SLOT_W)) i_framer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sync_in(sync_in),
        .master_en(master_en), .sync_bit_mode(sync_bit_mode),
        .sync_early(sync_early), .slot_len_sel(slot_len_sel),
        .word_len(word_len), .slots_m1(slots_m1), .rx_soft_rst(rx_soft_rst),
        .sync_out(sync_out), .cap_en(cap_en), .cap_first(cap_first),
        .cap_last(cap_last), .cap_slot(cap_slot)
    );

    tdm_rx_shifter #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_shifter (
        .clk(clk), .rst_n(rst_n), .sdata_in(sdata_in),
        .rx_soft_rst(rx_soft_rst), .word_ack(word_ack), .cap_en(cap_en),
        .cap_first(cap_first), .cap_last(cap_last), .cap_slot(cap_slot),
        .word_data(word_data), .word_valid(word_valid),
        .word_slot(word_slot), .overrun(overrun)
    );
endmodule

// File: tb/test_tdm_rx_sync.sv
module test_tdm_rx_sync;
    logic clk = 0, rst_n = 0, bit_tick = 0, sync_in = 0, sdata_in = 0;
    logic master_en = 0, sync_bit_mode = 0, sync_early = 0;
    logic [2:0] slot_len_sel = 3'd1;
    logic [5:0] word_len = 6'd16;
    logic [4:0] slots_m1 = 5'd3;
    logic rx_soft_rst = 0, word_ack = 0;
    logic sync_out, word_valid, overrun;
    logic [31:0] word_data;
    logic [4:0] word_slot;

    int n_chk = 0, n_fail = 0;
    logic [36:0] exp_q[$];
    logic mon_en = 1;
    logic [31:0] last_word;
    logic [4:0]  last_slot;

    always #10 clk = ~clk;

    tdm_rx_sync i_tdm_rx_sync (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sync_in(sync_in),
        .sdata_in(sdata_in), .master_en(master_en), .sync_bit_mode(sync_bit_mode),
        .sync_early(sync_early), .slot_len_sel(slot_len_sel), .word_len(word_len),
        .slots_m1(slots_m1), .rx_soft_rst(rx_soft_rst), .word_ack(word_ack),
        .sync_out(sync_out), .word_data(word_data), .word_valid(word_valid),
        .word_slot(word_slot), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a word is offered, then acknowledges.
    always @(negedge clk) begin
        #2;
        if (mon_en) begin
            if (word_valid && !word_ack) begin
                if (exp_q.size() == 0) begin
                    check(0, "R1 unexpected word", {27'd0, word_slot, word_data}, 0);
                end else begin
                    logic [36:0] e;
                    e = exp_q.pop_front();
                    check({word_slot, word_data} == e, "R1 word/slot", {27'd0, word_slot, word_data}, {27'd0, e});
                end
                word_ack = 1;
            end else begin
                word_ack = 0;
            end
        end
    end

    task automatic tick_bit(input logic sd, input logic sy, input bit chk, input logic exp_sync, input string req);
        @(negedge clk);
        if (chk) check(sync_out == exp_sync, req, sync_out, exp_sync);
        sdata_in = sd;
        sync_in  = sy;
        bit_tick = 1;
        @(negedge clk);
        bit_tick = 0;
        repeat (2) @(negedge clk);
    endtask

    function automatic bit sync_lvl(int p, int len, int wl, bit bm, bit er);
        if (bm) return p == 0;
        if (er) return (p < wl - 1) || (p == len - 1);
        return p < wl;
    endfunction

    // Driver: sends frames bit by bit and pushes the words the requirements predict.
    task automatic run(input int nfr, input int nsl, input int sl, input int wl,
                       input bit push, input string req);
        int len = nsl * sl;
        bit m = master_en, bm = sync_bit_mode, er = sync_early;
        if (!m && er && !bm) tick_bit($urandom % 2, 1, 0, 0, req);
        for (int f = 0; f < nfr; f++) begin
            for (int s = 0; s < nsl; s++) begin
                logic [31:0] w = 0;
                for (int b = 0; b < sl; b++) begin
                    logic d = 1'($urandom % 2);
                    int p = s * sl + b;
                    bit sy = sync_lvl(p, len, wl, bm, er);
                    if (!m && !bm && er && p == len - 1 && f == nfr - 1) sy = 0;
                    if (b < wl) w = {w[30:0], d};
                    if (b == wl - 1) begin
                        last_word = w;
                        last_slot = 5'(s);
                        if (push) exp_q.push_back({5'(s), w});
                    end
                    tick_bit(d, m ? 1'b0 : sy, m, sync_lvl(p, len, wl, bm, er), req);
                end
            end
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic drained(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic soft_pulse;
        @(negedge clk); rx_soft_rst = 1;
        @(negedge clk); rx_soft_rst = 0;
        @(negedge clk);
    endtask

    task automatic cfg(input bit m, input bit bm, input bit er, input logic [2:0] sel,
                       input int wl, input int nsl);
        master_en = m; sync_bit_mode = bm; sync_early = er;
        slot_len_sel = sel; word_len = 6'(wl); slots_m1 = 5'(nsl - 1);
        soft_pulse();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(word_valid == 0, "R9 reset valid", word_valid, 0);
        check(overrun == 0, "R10 reset overrun", overrun, 0);
        check(sync_out == 0, "R7 reset sync slave", sync_out, 0);
        rst_n = 1;
        @(negedge clk);

        // R4 R8: slave, on-time word sync, 16/16, 4 slots
        cfg(0, 0, 0, 3'd1, 16, 4); run(2, 4, 16, 16, 1, "R4"); drained("R4 all words");
        // R2: 12-bit words in 20-bit slots
        cfg(0, 0, 0, 3'd2, 12, 3); run(2, 3, 20, 12, 1, "R2"); drained("R2 all words");
        // R5: early word sync
        cfg(0, 0, 1, 3'd0, 12, 2); run(2, 2, 12, 12, 1, "R5"); drained("R5 all words");
        // R6: one-bit sync, early flag ignored
        cfg(0, 1, 1, 3'd4, 24, 2); run(2, 2, 32, 24, 1, "R6"); drained("R6 all words");
        // R7: master word sync, on time and early, and one-bit
        cfg(1, 0, 0, 3'd3, 24, 2); run(2, 2, 24, 24, 1, "R7 sync word"); drained("R7 words a");
        cfg(1, 0, 1, 3'd1, 16, 2); run(2, 2, 16, 16, 1, "R7 sync early"); drained("R7 words b");
        cfg(1, 1, 0, 3'd1, 8, 3);  run(2, 3, 16, 8, 1, "R7 sync bit"); drained("R7 words c");
        // R8: 32 slots and 1 slot per frame
        cfg(0, 0, 0, 3'd0, 12, 32); run(1, 32, 12, 12, 1, "R8"); drained("R8 32 slots");
        cfg(0, 1, 0, 3'd1, 16, 1);  run(2, 1, 16, 16, 1, "R8"); drained("R8 1 slot");

        // R3: reserved slot code in master mode, then word longer than slot
        cfg(1, 0, 0, 3'd5, 16, 2);
        for (int i = 0; i < 40; i++) tick_bit(1'($urandom % 2), 0, 1, 0, "R3 sync idle");
        check(word_valid == 0, "R3 reserved code no word", word_valid, 0);
        cfg(0, 0, 0, 3'd1, 20, 2); run(1, 2, 16, 20, 0, "R3");
        check(word_valid == 0, "R3 word>slot no word", word_valid, 0);

        // R10 R9: overrun with ack held off
        cfg(0, 0, 0, 3'd1, 16, 2);
        mon_en = 0; word_ack = 0;
        run(1, 2, 16, 16, 0, "R10");
        check(word_valid == 1, "R9 valid held", word_valid, 1);
        check(overrun == 1, "R10 overrun set", overrun, 1);
        check(word_data == last_word, "R10 newest word kept", word_data, last_word);
        check(word_slot == last_slot, "R10 newest slot", word_slot, last_slot);
        @(negedge clk); word_ack = 1; @(negedge clk); word_ack = 0; @(negedge clk);
        check(word_valid == 0, "R9 ack clears valid", word_valid, 0);
        check(overrun == 1, "R10 sticky after ack", overrun, 1);

        // R11: soft reset clears in the same cycle, blocks capture, keeps config
        @(negedge clk); rx_soft_rst = 1; #2;
        check(overrun == 0, "R11 immediate clear", overrun, 0);
        run(1, 2, 16, 16, 0, "R11");
        check(word_valid == 0, "R11 no capture in reset", word_valid, 0);
        master_en = 1; #2;
        check(sync_out == 0, "R11 sync gated", sync_out, 0);
        master_en = 0;
        @(negedge clk); rx_soft_rst = 0; mon_en = 1; @(negedge clk);
        run(1, 2, 16, 16, 1, "R11 resume"); drained("R11 resume words");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule